// File: doc/BRIEF.md
# Programmable-Latency Burst Read Sequencer

This block is the read side of a synchronous burst memory. The host presents a start address together with an address-valid strobe while chip enable is low. The sequencer then waits a programmed number of initial access cycles and streams one word per clock from its internal array model. A ready output tells the host when a word is on the data pins. The initial latency comes from a 3-bit setting. Odd start addresses and the 64-word regions that the array is organised in add latency.

A configuration write loads the setting from address bits 14..12. Software picks the fastest setting that the clock frequency allows. The `mode` input chooses the burst type. Continuous bursts increment linearly through the whole address space. Fixed bursts of 8, 16 or 32 words wrap inside their aligned 64-word region.

Top module: `wsburst_rd`

## Requirements
- R1: After reset, `rdy`, `dvalid` and `dout` are 0 and the setting is code 101 (7 cycles). A reset at any later time also restores code 101.
- R2: Let the start address be captured at clock edge E (the edge where `avd`=1 and `ce_n`=0). The first word is valid from edge E+L-1 onward, where L = code+2 for codes 000..101 with an even start address and no region penalty. Each further word follows on the next edge.
- R3: On a clock edge with `cfg_we`=1 and no burst active, the setting takes the value of `addr[14:12]`. The values 110 and 111 leave the setting unchanged. A write made while a burst is active is ignored.
- R4: When `cfg_we` and `avd` occur in the same idle cycle, the write takes effect. The burst started in that cycle still uses the setting held before the write.
- R5: `rdy` is high in every cycle where `dvalid` is high. While the setting is nonzero, `rdy` also goes high one cycle before the first word. With setting 000 it rises together with the first word.
- R6: A start address with bit 0 set adds one cycle to L.
- R7: In continuous mode (`mode`=00), a start address whose low six bits are 3Ch..3Fh adds two cycles to L, on top of the odd-address cycle. The first region crossing of that burst then has no gap.
- R8: In continuous mode, each other step from an address with low bits 3Fh into the next region inserts two cycles with `dvalid` and `rdy` both low.
- R9: Modes 01, 10 and 11 deliver exactly 8, 16 and 32 words. The address increments only in its low six bits, so the burst wraps from 3Fh to 00h within the same 64-word region. `dvalid` and `rdy` drop after the last word.
- R10: `ce_n`=1 ends any burst, so `dvalid` and `rdy` are low from the next edge on. A new `avd` capture during a burst discards it and restarts the latency count.
- R11: While `dvalid`=1, `dout` equals the low 16 bits of (address × 40503) XOR A5C3h. While `dvalid`=0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| avd | input | 1 | Address-valid strobe: captures `addr` as burst start |
| addr | input | 16 | Start address, or configuration code in bits 14..12 |
| mode | input | 2 | 00 continuous, 01 8-word, 10 16-word, 11 32-word |
| cfg_we | input | 1 | Configuration write strobe |
| rdy | output | 1 | Ready to the host |
| dvalid | output | 1 | A word is on `dout` this cycle |
| dout | output | 16 | Read data |

## Verification
A configuration write and a burst start can happen on the same clock edge, because both read the shared address bus. The bench puts a start address whose bits 14..12 carry a new legal code on the bus, and raises `cfg_we` with `avd` in one idle cycle. The scoreboard then expects the first word at the latency of the old code. It expects the following burst at the latency of the new code. In a related case, the bench issues a write during the wait phase of a running burst and checks that the next burst still runs at the old latency.

// File: rtl/wsburst_rd.sv
module wsburst_rd #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CFG_LSB = 12,
  parameter int RGN_BITS = 6,
  parameter int PREFETCH = 4,
  parameter int GAP = 2,
  parameter logic [2:0] RST_CODE = 3'd5,
  parameter logic [DW-1:0] MIX_MUL = 16'd40503,
  parameter logic [DW-1:0] MIX_XOR = 16'hA5C3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          avd,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  input  logic          cfg_we,
  output logic          rdy,
  output logic          dvalid,
  output logic [DW-1:0] dout
);
  localparam int RGN = 1 << RGN_BITS;
  localparam int CW  = 4;
  localparam int LW  = 6;

  logic [2:0]    code;
  logic          act, cont, stl, paid;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ptr;
  logic [LW-1:0] left;
  logic [LW-1:0] blen;

  wire [2:0] wcode   = addr[CFG_LSB+2:CFG_LSB];
  wire       cfg_ok  = cfg_we & ~act & (wcode <= 3'd5);
  wire       near_end = (mode == 2'd0) &&
                        (addr[RGN_BITS-1:0] >= RGN_BITS'(RGN - PREFETCH));
  wire [CW-1:0] lat  = CW'(code) + CW'(2) + CW'(addr[0]) +
                       (near_end ? CW'(GAP) : CW'(0));
  wire          at_edge = &ptr[RGN_BITS-1:0];
  wire [RGN_BITS-1:0] nxt_lo = ptr[RGN_BITS-1:0] + RGN_BITS'(1);

  always_comb begin
    case (mode)
      2'd1:    blen = LW'(8);
      2'd2:    blen = LW'(16);
      2'd3:    blen = LW'(32);
      default: blen = LW'(0);
    endcase
  end

  assign dvalid = act & (cnt == '0);
  assign rdy    = dvalid | (act & (cnt == CW'(1)) & ~stl & (code != 3'd0));
  assign dout   = dvalid ? (DW'(DW'(ptr) * MIX_MUL) ^ MIX_XOR) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= RST_CODE;
      act  <= 1'b0;
      cont <= 1'b0;
      stl  <= 1'b0;
      paid <= 1'b0;
      cnt  <= '0;
      ptr  <= '0;
      left <= '0;
    end else begin
      if (cfg_ok) code <= wcode;
      if (ce_n) begin
        act <= 1'b0;
      end else if (avd) begin
        act  <= 1'b1;
        cont <= (mode == 2'd0);
        ptr  <= addr;
        cnt  <= lat - CW'(1);
        left <= blen;
        stl  <= 1'b0;
        paid <= near_end;
      end else if (act) begin
        if (cnt != '0) begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) stl <= 1'b0;
        end else begin
          left <= left - LW'(1);
          if (cont) begin
            ptr <= ptr + AW'(1);
            if (at_edge) begin
              if (paid) paid <= 1'b0;
              else begin
                cnt <= CW'(GAP);
                stl <= 1'b1;
              end
            end
          end else begin
            ptr <= {ptr[AW-1:RGN_BITS], nxt_lo};
            if (left == LW'(1)) act <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wsburst_rd_chk.sv
module wsburst_rd_chk #(
  parameter int AW = 16,
  parameter int RGN_BITS = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          avd,
  input logic          rdy,
  input logic          dvalid,
  input logic [2:0]    code,
  input logic          act,
  input logic          cont,
  input logic [AW-1:0] ptr
);
  AST_DATA_HAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> rdy); // R5
  AST_FAST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'd0 && !dvalid) |-> !rdy); // R5
  AST_EARLY_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !dvalid && !ce_n && !avd) |=> dvalid); // R5
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!dvalid && !rdy)); // R10
  AST_CODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> $stable(code)); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code <= 3'd5); // R3
  AST_REGION_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && !cont && $past(dvalid) && !$past(avd)) |->
      ptr[AW-1:RGN_BITS] == $past(ptr[AW-1:RGN_BITS])); // R9
endmodule

bind wsburst_rd wsburst_rd_chk #(.AW(AW), .RGN_BITS(RGN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .avd(avd), .rdy(rdy),
  .dvalid(dvalid), .code(code), .act(act), .cont(cont), .ptr(ptr)
);

// File: tb/sim_wsburst_rd.sv
module sim_wsburst_rd;
  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, avd = 1'b0, cfg_we = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  mode = '0;
  logic        rdy, dvalid;
  logic [15:0] dout;

  always #5 clk = ~clk;

  wsburst_rd u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .avd(avd), .addr(addr),
                 .mode(mode), .cfg_we(cfg_we), .rdy(rdy), .dvalid(dvalid), .dout(dout));

  typedef struct { int t; logic [15:0] a; } item_t;
  item_t sbq[$];
  item_t e;
  int cyc = 0, nv = 0, nf = 0, mcode = 5;
  string cur_tag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] model(logic [15:0] a);
    logic [15:0] p;
    p = a * 16'd40503;
    return p ^ 16'hA5C3;
  endfunction

  function automatic bit has(int q[$], int v);
    foreach (q[i]) if (q[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act_v, longint exp_v);
    nv++;
    if (!ok) begin
      nf++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act_v, exp_v);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (dvalid) begin
      if (sbq.size() == 0) chk(1'b0, "R10", "unexpected word", dout, 0);
      else begin
        e = sbq.pop_front();
        chk(cyc == e.t, cur_tag, "word cycle", cyc, e.t);
        chk(dout == model(e.a), "R11", "word data", dout, model(e.a));
      end
    end else begin
      if (dout != 16'h0) chk(1'b0, "R11", "idle data", dout, 0);
      if (sbq.size() != 0 && sbq[0].t < cyc) begin
        e = sbq.pop_front();
        chk(1'b0, cur_tag, "missing word", cyc, e.t);
      end
    end
  end

  task automatic cfg(input int c);
    @(negedge clk);
    cfg_we = 1'b1; addr = {1'b0, 3'(c), 12'h0};
    if (c <= 5) mcode = c;
    @(negedge clk);
    cfg_we = 1'b0; addr = '0;
  endtask

  task automatic run_burst(input logic [15:0] a, input logic [1:0] md, input int nw,
                           input bit cfg_same, input int mid_code, input string tag);
    int L, C, F, t, blen, ex, last;
    logic [15:0] p;
    bit paid, rok, xp;
    int ts[$];
    paid = (md == 2'd0) && (a[5:0] >= 6'd60);
    L = mcode + 2 + int'(a[0]) + (paid ? 2 : 0);
    blen = (md == 2'd1) ? 8 : (md == 2'd2) ? 16 : (md == 2'd3) ? 32 : nw;
    cur_tag = tag;
    @(negedge clk);
    avd = 1'b1; addr = a; mode = md; cfg_we = cfg_same;
    C = cyc + 1;
    if (cfg_same && a[14:12] <= 3'd5) mcode = int'(a[14:12]);
    F = C + L - 1; t = F; p = a;
    for (int i = 0; i < blen; i++) begin
      sbq.push_back('{t, p}); ts.push_back(t);
      if (md == 2'd0) begin
        if (p[5:0] == 6'h3F) begin
          if (paid) begin paid = 1'b0; t += 1; end else t += 3;
        end else t += 1;
        p = p + 16'd1;
      end else begin
        t += 1; p = {p[15:6], 6'(p[5:0] + 6'd1)};
      end
    end
    last = ts[ts.size()-1];
    @(negedge clk);
    avd = 1'b0; cfg_we = 1'b0; addr = '0;
    rok = 1'b1; ex = 0;
    forever begin
      if (mid_code >= 0 && cyc == C) begin cfg_we = 1'b1; addr = {1'b0, 3'(mid_code), 12'h0}; end
      else if (cyc == C + 1) begin cfg_we = 1'b0; addr = '0; end
      xp = has(ts, cyc) || (mcode != 0 && cyc < F && has(ts, cyc + 1));
      if (rdy !== xp && rok) begin rok = 1'b0; ex = cyc; end
      if (cyc >= last) break;
      @(negedge clk);
    end
    if (md == 2'd0) ce_n = 1'b1;
    chk(rok, (tag == "R8") ? "R8" : "R5", "rdy pattern ok (first bad cycle offset)", ex - C, 0);
    @(negedge clk);
    chk(!dvalid && !rdy, (md == 2'd0) ? "R10" : "R9", "quiet after burst", {dvalid, rdy}, 0);
    ce_n = 1'b0; cfg_we = 1'b0; addr = '0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nv, nf);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nf++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rdy && !dvalid && dout == 0, "R1", "reset outputs", {rdy, dvalid, dout}, 0);
    rst_n = 1'b1; ce_n = 1'b0;
    @(negedge clk);
    chk(!rdy && !dvalid && dout == 0, "R11", "idle outputs", {rdy, dvalid, dout}, 0);
    run_burst(16'h0010, 2'd1, 0, 0, -1, "R1");
    for (int c = 0; c < 6; c++) begin
      cfg(c);
      run_burst(16'h0100 + 16'(c * 16), 2'd1, 0, 0, -1, "R2");
    end
    cfg(0); run_burst(16'h0200, 2'd1, 0, 0, -1, "R5");
    cfg(3); run_burst(16'h0208, 2'd1, 0, 0, -1, "R5");
    cfg(2); run_burst(16'h0021, 2'd2, 0, 0, -1, "R6");
    cfg(0); run_burst(16'h0023, 2'd1, 0, 0, -1, "R6");
    cfg(2); cfg(6); run_burst(16'h0040, 2'd1, 0, 0, -1, "R3");
    cfg(7); run_burst(16'h0048, 2'd1, 0, 0, -1, "R3");
    run_burst(16'h0080, 2'd1, 0, 0, 4, "R3");
    run_burst(16'h0090, 2'd1, 0, 0, -1, "R3");
    run_burst(16'h3050, 2'd1, 0, 1, -1, "R4");
    run_burst(16'h0060, 2'd1, 0, 0, -1, "R4");
    run_burst(16'h0138, 2'd2, 0, 0, -1, "R9");
    run_burst(16'h0231, 2'd3, 0, 0, -1, "R9");
    run_burst(16'h003C, 2'd0, 72, 0, -1, "R7");
    run_burst(16'h013D, 2'd0, 6, 0, -1, "R7");
    run_burst(16'h0030, 2'd0, 20, 0, -1, "R8");
    cfg(0); run_burst(16'h0335, 2'd0, 14, 0, -1, "R8");
    cfg(5);
    @(negedge clk); avd = 1'b1; addr = 16'h0400; mode = 2'd1;
    @(negedge clk); avd = 1'b0; addr = '0;
    @(negedge clk);
    run_burst(16'h0500, 2'd1, 0, 0, -1, "R10");
    cfg(1);
    @(negedge clk); rst_n = 1'b0; mcode = 5;
    @(negedge clk);
    chk(!rdy && !dvalid, "R1", "outputs in reset", {rdy, dvalid}, 0);
    rst_n = 1'b1;
    run_burst(16'h0010, 2'd1, 0, 0, -1, "R1");
    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R2", "scoreboard drained", sbq.size(), 0);
    summary();
  end
endmodule